// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block keeps an alarm time in packed BCD and compares it with the current calendar time, which a separate counter supplies on an input bus. Each of the seven alarm fields has its own compare-enable flag. A field whose flag is clear takes no part in the comparison. On a seconds tick, if every enabled field equals the current time, a sticky status bit is set. Software clears that bit by writing a one to it.

Software loads the alarm through a simple register write port. Field writes go into staging registers. A single commit write then copies all seven staged fields, with their flags, into the compared copy at the same time. This prevents a half-updated alarm from matching while the fields are being written. The interrupt output is a level. It is the status bit gated by an interrupt-enable bit.

Top module: `alarm_match_irq`

## Requirements
- R1: After reset, the status bit, the interrupt enable, every compare flag and every committed field read as zero, and `irq` is low.
- R2: Register addresses 0 to 6 stage the fields seconds, minutes, hours, weekday, day, month and year. In each, the value sits in the low bits and bit 15 is the compare flag. A write to address 7 with bit 15 set copies all seven staged fields into the committed alarm in one cycle. A write to address 7 with bit 15 clear, or any field write alone, leaves the committed alarm unchanged. Reading addresses 0 to 6 returns the committed field as {flag, zeros, value}.
- R3: On a cycle with `tick` high, status becomes 1 when every field whose committed flag is set equals its slice of `cur_time`. Fields whose flag is clear are ignored. A single differing enabled field, including weekday when its flag is set, prevents the set.
- R4: Without `tick`, a matching time never sets the status bit.
- R5: If no compare flag is set in the committed alarm, the status bit is never set.
- R6: Address 9 is the status. Bit 0 reads the status bit. Writing 1 to bit 0 clears it, and writing 0 leaves it as it is. When a set and a clear fall in the same cycle, the set wins.
- R7: Address 8 bit 0 is the interrupt enable. `irq` is high exactly while both the status bit and the enable are 1, and it stays high for as long as that holds.
- R8: Field values are cut to their widths: seconds 7, minutes 7, hours 6, weekday 3, day 6, month 5 and year 8 bits. Bits between the value and bit 15 read back as zero. `cur_time` packs the same fields as seconds [6:0], minutes [13:7], hours [19:14], weekday [22:20], day [28:23], month [33:29] and year [41:34].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse per elapsed second |
| cur_time | input | 42 | Current calendar fields, packed BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: 16-bit data, a 4-bit address and the compare flag at bit 15. With these values the flag lands above every field value, so a write of all ones shows the masking of each field width. The bench covers the commit path, each field taking part in or leaving the match, the weekday flag, a set and a clear in the same cycle, and an alarm with no flag set. A behavioural model tracks staging, committed alarm, enable and status on every clock, and compares `irq` and the read port against it.

// File: rtl/alarm_match_pkg.sv
`timescale 1ns/1ps
// Package: field layout and register addresses for the alarm match block.
// Assumes seven calendar fields packed LSB-first, seconds lowest.
package alarm_match_pkg;

    localparam int NUM_FIELDS = 7;

    // Width of each BCD field: sec, min, hour, wday, day, month, year.
    function automatic int field_w(input int idx);
        case (idx)
            0:       return 7;
            1:       return 7;
            2:       return 6;
            3:       return 3;
            4:       return 6;
            5:       return 5;
            default: return 8;
        endcase
    endfunction

    // Bit position of a field inside the packed time bus.
    function automatic int field_lsb(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += field_w(k);
        return acc;
    endfunction

    localparam int TIME_W     = field_lsb(NUM_FIELDS);
    localparam int REG_COMMIT = 7;
    localparam int REG_IRQ_EN = 8;
    localparam int REG_STATUS = 9;

endpackage

// File: rtl/alarm_match_field.sv
`timescale 1ns/1ps
// Module: compares one alarm field with its current value.
// Assumes both operands have the same BCD width; a disabled field always hits.
module alarm_match_field #(
    parameter int W = 8
) (
    input  logic         cmp_en,
    input  logic [W-1:0] alarm,
    input  logic [W-1:0] now,
    output logic         hit
);

    // Hit when the field is excluded or equal.
    assign hit = !cmp_en || (alarm == now);

endmodule

// File: rtl/alarm_match_regs.sv
`timescale 1ns/1ps
// Module: register file for the alarm: staged fields, committed fields,
// interrupt enable and the write-one-to-clear request for the status bit.
// Assumes one write per cycle; commit copies the staging as of before the edge.
module alarm_match_regs
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int EN_BIT = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [TIME_W-1:0]     alm_val,
    output logic [NUM_FIELDS-1:0] alm_en,
    output logic                  irq_en,
    output logic                  sts_clr
);

    logic commit;
    logic unused_data;

    assign unused_data = ^wr_data;
    assign commit  = wr_en && (wr_addr == ADDR_W'(REG_COMMIT)) && wr_data[EN_BIT];
    assign sts_clr = wr_en && (wr_addr == ADDR_W'(REG_STATUS)) && wr_data[0];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int W   = field_w(g);
        localparam int LSB = field_lsb(g);
        logic [W-1:0] stg_val, sh_val;
        logic         stg_en, sh_en;
        logic         wr_sel;

        assign wr_sel = wr_en && (wr_addr == ADDR_W'(g));

        // Capture a field write into the staging copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_val <= '0;
                stg_en  <= 1'b0;
            end else if (wr_sel) begin
                stg_val <= wr_data[W-1:0];
                stg_en  <= wr_data[EN_BIT];
            end
        end

        // Move the staged field into the compared copy on commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_val <= '0;
                sh_en  <= 1'b0;
            end else if (commit) begin
                sh_val <= stg_val;
                sh_en  <= stg_en;
            end
        end

        assign alm_val[LSB +: W] = sh_val;
        assign alm_en[g]         = sh_en;
    end

    // Hold the interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= 1'b0;
        else if (wr_en && (wr_addr == ADDR_W'(REG_IRQ_EN)))
            irq_en <= wr_data[0];
    end

endmodule

// File: rtl/alarm_match_status.sv
`timescale 1ns/1ps
// Module: sticky match status and the gated level interrupt.
// Assumes tick is one cycle wide; a set beats a clear in the same cycle.
module alarm_match_status (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic all_hit,
    input  logic any_en,
    input  logic clr,
    input  logic irq_en,
    output logic sts,
    output logic set_evt,
    output logic irq
);

    assign set_evt = tick && all_hit && any_en;

    // Set on a matching second, clear on a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts <= 1'b0;
        else if (set_evt)
            sts <= 1'b1;
        else if (clr)
            sts <= 1'b0;
    end

    assign irq = sts && irq_en;

endmodule

// File: rtl/alarm_match_irq.sv
`timescale 1ns/1ps
// Module: top of the calendar alarm match interrupt.
// Assumes cur_time is valid whenever tick is high; the read port is combinational.
module alarm_match_irq
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int EN_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic [TIME_W-1:0]     alm_val;
    logic [NUM_FIELDS-1:0] alm_en;
    logic [NUM_FIELDS-1:0] hits;
    logic                  irq_en, sts_clr, sts, set_evt, any_en;
    logic [DATA_W-1:0]     fld_word [NUM_FIELDS];

    alarm_match_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alm_val(alm_val), .alm_en(alm_en),
        .irq_en(irq_en), .sts_clr(sts_clr)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        localparam int W   = field_w(g);
        localparam int LSB = field_lsb(g);

        alarm_match_field #(.W(W)) u_field (
            .cmp_en(alm_en[g]), .alarm(alm_val[LSB +: W]),
            .now(cur_time[LSB +: W]), .hit(hits[g])
        );

        assign fld_word[g] = DATA_W'(alm_val[LSB +: W]) | (DATA_W'(alm_en[g]) << EN_BIT);
    end

    assign any_en = |alm_en;

    alarm_match_status u_status (
        .clk(clk), .rst_n(rst_n), .tick(tick), .all_hit(&hits),
        .any_en(any_en), .clr(sts_clr), .irq_en(irq_en),
        .sts(sts), .set_evt(set_evt), .irq(irq)
    );

    // Select the register addressed by rd_addr.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_FIELDS; k++)
            if (rd_addr == ADDR_W'(k)) rd_data = fld_word[k];
        if (rd_addr == ADDR_W'(REG_IRQ_EN)) rd_data = DATA_W'(irq_en);
        if (rd_addr == ADDR_W'(REG_STATUS)) rd_data = DATA_W'(sts);
    end

endmodule

// File: rtl/alarm_match_irq_chk.sv
`timescale 1ns/1ps
// Module: temporal checks on the alarm match block, attached by bind.
// Assumes the top's internal status, enable and committed alarm names.
module alarm_match_irq_chk
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int EN_BIT = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  sts,
    input logic                  irq_en,
    input logic                  set_evt,
    input logic                  any_en,
    input logic [TIME_W-1:0]     alm_val,
    input logic [NUM_FIELDS-1:0] alm_en
);

    logic clr_req, commit_req;
    assign clr_req    = wr_en && (wr_addr == ADDR_W'(REG_STATUS)) && wr_data[0];
    assign commit_req = wr_en && (wr_addr == ADDR_W'(REG_COMMIT)) && wr_data[EN_BIT];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sts && !irq_en && alm_en == '0));

    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_req |=> ($stable(alm_val) && $stable(alm_en)));

    assert_rise_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(tick));

    assert_rise_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(any_en));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !sts);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !clr_req) |=> sts);

endmodule

bind alarm_match_irq alarm_match_irq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sts(sts), .irq_en(irq_en), .set_evt(set_evt),
    .any_en(any_en), .alm_val(alm_val), .alm_en(alm_en)
);

// File: tb/alarm_match_irq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural model of staging, commit, match, status and enable,
// compared with irq and the read port on every clock, plus directed checks.
module alarm_match_irq_bench;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int TW     = 42;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [TW-1:0]     cur_time = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    always #4 clk = ~clk;

    alarm_match_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(15)) u_alarm_match_irq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cur_time(cur_time),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    int bw [7] = '{7, 7, 6, 3, 6, 5, 8};
    int now_f [7];
    int st_v [7], st_e [7], sh_v [7], sh_e [7];
    bit m_ie, m_sts, m_any, m_hit, m_set;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint model_read(input int a);
        if (a < 7) return (longint'(sh_e[a]) << 15) | sh_v[a];
        if (a == 8) return m_ie;
        if (a == 9) return m_sts;
        return 0;
    endfunction

    // Reference model, updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 7; k++) begin
                st_v[k] = 0; st_e[k] = 0; sh_v[k] = 0; sh_e[k] = 0;
            end
            m_ie = 0; m_sts = 0;
        end else begin
            m_any = 0; m_hit = 1;
            for (int k = 0; k < 7; k++)
                if (sh_e[k] != 0) begin
                    m_any = 1;
                    if (sh_v[k] != now_f[k]) m_hit = 0;
                end
            m_set = tick && m_any && m_hit;
            if (wr_en && wr_addr == 7 && wr_data[15])
                for (int k = 0; k < 7; k++) begin
                    sh_v[k] = st_v[k]; sh_e[k] = st_e[k];
                end
            if (wr_en && wr_addr < 7) begin
                st_v[wr_addr] = int'(wr_data) & ((1 << bw[wr_addr]) - 1);
                st_e[wr_addr] = int'(wr_data[15]);
            end
            if (wr_en && wr_addr == 8) m_ie = wr_data[0];
            if (m_set) m_sts = 1;
            else if (wr_en && wr_addr == 9 && wr_data[0]) m_sts = 0;
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 irq vs model", irq, m_sts && m_ie);
            check("R2 read vs model", rd_data, model_read(int'(rd_addr)));
        end
    end

    task automatic set_now(input int s, mi, h, wd, d, mo, y);
        longint acc;
        int sh;
        now_f[0] = s; now_f[1] = mi; now_f[2] = h; now_f[3] = wd;
        now_f[4] = d; now_f[5] = mo; now_f[6] = y;
        acc = 0; sh = 0;
        for (int k = 0; k < 7; k++) begin
            acc |= longint'(now_f[k] & ((1 << bw[k]) - 1)) << sh;
            sh += bw[k];
        end
        cur_time = acc[TW-1:0];
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); #1 tick = 1;
        @(negedge clk); #1 tick = 0;
    endtask

    task automatic rd(input int a, input longint exp, input string tag);
        @(negedge clk); #1 rd_addr = ADDR_W'(a);
        #1 check(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        set_now(0, 0, 0, 0, 0, 0, 0);
        idle(5);
        #1 rst_n = 1;
        rd(9, 0, "R1 status after reset");
        rd(8, 0, "R1 enable after reset");
        rd(0, 0, "R1 field after reset");
        check("R1 irq after reset", irq, 0);

        wr(0, 'h8056); wr(1, 'h8034); wr(2, 'h8012); wr(3, 'h0003);
        wr(4, 'h8015); wr(5, 'h8006); wr(6, 'h8025);
        rd(0, 0, "R2 staged field not visible");
        wr(7, 'h7FFF);
        rd(0, 0, "R2 commit without bit 15");
        wr(7, 'h8000);
        rd(0, 'h8056, "R2 committed seconds");
        rd(3, 'h0003, "R2 committed weekday");
        rd(6, 'h8025, "R2 committed year");

        set_now('h56, 'h34, 'h12, 5, 'h15, 'h06, 'h25);
        idle(4);
        rd(9, 0, "R4 no tick no set");
        pulse_tick();
        rd(9, 1, "R3 match with weekday excluded");
        check("R7 irq masked", irq, 0);
        wr(8, 1);
        check("R7 irq raised", irq, 1);
        idle(3);
        check("R7 irq level held", irq, 1);
        wr(9, 0);
        rd(9, 1, "R6 write zero keeps status");
        wr(9, 1);
        rd(9, 0, "R6 write one clears");
        check("R7 irq dropped", irq, 0);

        set_now('h57, 'h34, 'h12, 5, 'h15, 'h06, 'h25);
        pulse_tick();
        rd(9, 0, "R3 seconds mismatch");

        wr(3, 'h8003); wr(7, 'h8000);
        set_now('h56, 'h34, 'h12, 5, 'h15, 'h06, 'h25);
        pulse_tick();
        rd(9, 0, "R3 weekday mismatch blocks");
        set_now('h56, 'h34, 'h12, 3, 'h15, 'h06, 'h25);
        pulse_tick();
        rd(9, 1, "R3 weekday match");

        @(negedge clk); #1;
        tick = 1; wr_en = 1; wr_addr = 9; wr_data = 1;
        @(negedge clk); #1;
        tick = 0; wr_en = 0;
        rd(9, 1, "R6 set wins over clear");
        wr(9, 1);
        rd(9, 0, "R6 cleared after");

        wr(0, 'hFFFF); wr(2, 'hFFFF); wr(7, 'h8000);
        rd(0, 'h807F, "R8 seconds masked");
        rd(2, 'h803F, "R8 hours masked");

        for (int k = 0; k < 7; k++) wr(k, 0);
        wr(7, 'h8000);
        set_now(0, 0, 0, 0, 0, 0, 0);
        pulse_tick();
        rd(9, 0, "R5 no flag never fires");
        check("R5 irq stays low", irq, 0);

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule